// File: doc/BRIEF.md
# FIFO Event Interrupt Register Block

This block sits beside the transmit and receive FIFOs of an SPI host controller and turns their occupancy counts and error pulses into a small set of interrupt registers. It derives six event flags: receive overflow, transmit at or below its low watermark, transmit full, receive at its high watermark, receive full and transmit underflow. It latches them into a status register that software clears by writing ones. An enable mask decides which flags drive a single level interrupt line.

The mask has no direct write access. One register address sets mask bits wherever the written word has ones. Another address clears mask bits the same way. A read-only address returns the current mask. Two watermark registers hold the transmit and receive thresholds that the flag comparisons use. Software reads the status register and writes the same value back to acknowledge the interrupt.

Top module: `fifo_irq_regs`

## Requirements
- R1: After reset the status register and mask read 0, the interrupt output is 0, the transmit watermark reads 1 and the receive watermark reads 32.
- R2: A write to the enable address (0x08) sets each mask bit whose data bit is 1 and leaves the others unchanged. The mask reads at 0x10. Only bits 0 and 2 to 6 exist, and the others always read 0.
- R3: A write to the disable address (0x0C) clears each mask bit whose data bit is 1 and leaves the others unchanged.
- R4: Reads of the enable and disable addresses, and of any unmapped address, return 0.
- R5: Status bit 2 is set while the transmit occupancy is strictly less than the transmit watermark. With a watermark of 1 this means the FIFO is empty.
- R6: Status bit 3 is set while the transmit occupancy equals the FIFO depth. Status bit 5 is set while the receive occupancy equals the FIFO depth.
- R7: Status bit 4 is set while the receive occupancy is greater than or equal to the receive watermark.
- R8: A one-cycle receive overflow pulse sets status bit 0, and a one-cycle transmit underflow pulse sets status bit 6. Each bit stays 1 after the pulse ends until software clears it.
- R9: A write to the status address (0x04) clears each status bit whose data bit is 1 and leaves the others. A bit whose source event is present in the clearing cycle stays 1.
- R10: The interrupt output is 1 exactly when some bit is 1 in both the status register and the mask, delayed by one clock.
- R11: Read data is registered. It shows the addressed register one clock after the address is presented.
- R12: The watermark registers at 0x28 (transmit) and 0x2C (receive) are writable and read back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_ovf_pulse | input | 1 | Receive overflow event, one cycle |
| tx_udf_pulse | input | 1 | Transmit underflow event, one cycle |
| irq | output | 1 | Level interrupt output |

## Verification
Each result has a fixed latency. A change in occupancy, an event pulse or a status write reaches the status register at the next rising edge. Mask writes take effect at that same edge. The interrupt follows the status and mask registers one edge later. Read data appears one edge after the address. The bench changes inputs on falling edges. It reads a register only after the edge that updates the register, and it checks the interrupt two falling edges after a mask write, which matches that count.

// File: rtl/fir_pkg.sv
`timescale 1ns/1ps
package fir_pkg;
  localparam int FLAG_W     = 7;
  localparam int B_RX_OVF   = 0;
  localparam int B_TX_LOW   = 2;
  localparam int B_TX_FULL  = 3;
  localparam int B_RX_AVAIL = 4;
  localparam int B_RX_FULL  = 5;
  localparam int B_TX_UDF   = 6;
  // bits that exist in status and mask (bit 1 is unused)
  localparam logic [FLAG_W-1:0] FLAG_IMPL = 7'b111_1101;

  localparam logic [7:0] A_STATUS  = 8'h04;
  localparam logic [7:0] A_ENABLE  = 8'h08;
  localparam logic [7:0] A_DISABLE = 8'h0C;
  localparam logic [7:0] A_MASK    = 8'h10;
  localparam logic [7:0] A_TX_WM   = 8'h28;
  localparam logic [7:0] A_RX_WM   = 8'h2C;
endpackage

// File: rtl/fir_event_cond.sv
`timescale 1ns/1ps
module fir_event_cond
  import fir_pkg::*;
#(
  parameter int DEPTH = 63,
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_wm,
  input  logic [LVL_W-1:0]  rx_wm,
  input  logic              rx_ovf_pulse,
  input  logic              tx_udf_pulse,
  output logic [FLAG_W-1:0] raw
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  always_comb begin
    raw             = '0;
    raw[B_RX_OVF]   = rx_ovf_pulse;
    raw[B_TX_LOW]   = (tx_level < tx_wm);
    raw[B_TX_FULL]  = (tx_level == FULL_LVL);
    raw[B_RX_AVAIL] = (rx_level >= rx_wm);
    raw[B_RX_FULL]  = (rx_level == FULL_LVL);
    raw[B_TX_UDF]   = tx_udf_pulse;
  end
endmodule

// File: rtl/fir_status_bank.sv
`timescale 1ns/1ps
module fir_status_bank #(
  parameter int               W    = 7,
  parameter logic [W-1:0]     IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] clr,
  output logic [W-1:0] st
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      // a present event wins over a clear in the same cycle
      always_ff @(posedge clk) begin
        if (rst) st[i] <= 1'b0;
        else     st[i] <= raw[i] | (st[i] & ~clr[i]);
      end
    end else begin : g_tie
      assign st[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fir_mask_bank.sv
`timescale 1ns/1ps
module fir_mask_bank #(
  parameter int           W    = 7,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] mask
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)           mask[i] <= 1'b0;
        else if (set_v[i]) mask[i] <= 1'b1;
        else if (clr_v[i]) mask[i] <= 1'b0;
      end
    end else begin : g_tie
      assign mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fifo_irq_regs.sv
`timescale 1ns/1ps
module fifo_irq_regs
  import fir_pkg::*;
#(
  parameter int DEPTH     = 63,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int TX_WM_RST = 1,
  parameter int RX_WM_RST = 32,
  parameter int LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_ovf_pulse,
  input  logic              tx_udf_pulse,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] AD_STATUS  = ADDR_W'(A_STATUS);
  localparam logic [ADDR_W-1:0] AD_ENABLE  = ADDR_W'(A_ENABLE);
  localparam logic [ADDR_W-1:0] AD_DISABLE = ADDR_W'(A_DISABLE);
  localparam logic [ADDR_W-1:0] AD_MASK    = ADDR_W'(A_MASK);
  localparam logic [ADDR_W-1:0] AD_TX_WM   = ADDR_W'(A_TX_WM);
  localparam logic [ADDR_W-1:0] AD_RX_WM   = ADDR_W'(A_RX_WM);
  localparam logic [LVL_W-1:0]  FULL_LVL   = LVL_W'(DEPTH);

  logic [FLAG_W-1:0] raw, status, mask;
  logic [FLAG_W-1:0] wflags, st_clr, m_set, m_clr;
  logic [LVL_W-1:0]  tx_wm, rx_wm;

  assign wflags = reg_wdata[FLAG_W-1:0];
  assign st_clr = (reg_wr && reg_addr == AD_STATUS)  ? wflags : '0;
  assign m_set  = (reg_wr && reg_addr == AD_ENABLE)  ? wflags : '0;
  assign m_clr  = (reg_wr && reg_addr == AD_DISABLE) ? wflags : '0;

  // watermark registers
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_wm <= LVL_W'(TX_WM_RST);
      rx_wm <= LVL_W'(RX_WM_RST);
    end else if (reg_wr) begin
      if (reg_addr == AD_TX_WM) tx_wm <= reg_wdata[LVL_W-1:0];
      if (reg_addr == AD_RX_WM) rx_wm <= reg_wdata[LVL_W-1:0];
    end
  end

  fir_event_cond #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cond (
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .tx_wm        (tx_wm),
    .rx_wm        (rx_wm),
    .rx_ovf_pulse (rx_ovf_pulse),
    .tx_udf_pulse (tx_udf_pulse),
    .raw          (raw)
  );

  fir_status_bank #(.W(FLAG_W), .IMPL(FLAG_IMPL)) u_status (
    .clk (clk),
    .rst (rst),
    .raw (raw),
    .clr (st_clr),
    .st  (status)
  );

  fir_mask_bank #(.W(FLAG_W), .IMPL(FLAG_IMPL)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .set_v (m_set),
    .clr_v (m_clr),
    .mask  (mask)
  );

  // registered read data and interrupt line
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(status & mask);
      case (reg_addr)
        AD_STATUS: reg_rdata <= DATA_W'(status);
        AD_MASK:   reg_rdata <= DATA_W'(mask);
        AD_TX_WM:  reg_rdata <= DATA_W'(tx_wm);
        AD_RX_WM:  reg_rdata <= DATA_W'(rx_wm);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  // R2: enable write sets the addressed mask bits
  a_r2_enable_sets: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AD_ENABLE) |=>
      ((mask & $past(wflags) & FLAG_IMPL) == ($past(wflags) & FLAG_IMPL)));

  // R3: disable write clears the addressed mask bits
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AD_DISABLE) |=> ((mask & $past(wflags)) == '0));

  // R8: overflow pulse always lands in the status register
  a_r8_ovf_sets: assert property (@(posedge clk) disable iff (rst)
    rx_ovf_pulse |=> status[B_RX_OVF]);

  // R9: clearing a sticky bit with no new event removes it
  a_r9_w1c_sticky: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AD_STATUS && reg_wdata[B_RX_OVF] && !rx_ovf_pulse)
      |=> !status[B_RX_OVF]);

  // R6: full transmit FIFO is seen in status
  a_r6_tx_full: assert property (@(posedge clk) disable iff (rst)
    (tx_level == FULL_LVL) |=> status[B_TX_FULL]);

  // R10: no enabled pending bit means no interrupt next cycle
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) == '0) |=> !irq);
endmodule

// File: tb/fifo_irq_regs_bench.sv
`timescale 1ns/1ps
module fifo_irq_regs_bench;
  localparam int LW = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [LW-1:0] tx_level, rx_level;
  logic        rx_ovf_pulse, tx_udf_pulse;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fifo_irq_regs u_fifo_irq_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_level(tx_level), .rx_level(rx_level),
    .rx_ovf_pulse(rx_ovf_pulse), .tx_udf_pulse(tx_udf_pulse), .irq(irq)
  );

  // {tx_level, rx_level, tx_wm, rx_wm, expected status}
  localparam logic [30:0] VEC [8] = '{
    {6'd0,  6'd0,  6'd1,  6'd32, 7'h04},
    {6'd63, 6'd63, 6'd1,  6'd32, 7'h38},
    {6'd5,  6'd31, 6'd8,  6'd32, 7'h04},
    {6'd8,  6'd32, 6'd8,  6'd32, 7'h10},
    {6'd0,  6'd1,  6'd0,  6'd1,  7'h10},
    {6'd62, 6'd62, 6'd63, 6'd63, 7'h04},
    {6'd63, 6'd0,  6'd63, 6'd0,  7'h18},
    {6'd1,  6'd1,  6'd1,  6'd1,  7'h10}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_level = 6'd10; rx_level = 6'd0;
    rx_ovf_pulse = 1'b0; tx_udf_pulse = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst = 1'b0;
    rd(8'h04, d); chk("R1 status after reset", d, 32'h0);
    rd(8'h10, d); chk("R1 mask after reset", d, 32'h0);
    rd(8'h28, d); chk("R1 tx watermark reset", d, 32'd1);
    rd(8'h2C, d); chk("R1 rx watermark reset", d, 32'd32);

    // R11: read latency of one clock; R4 write-only and unmapped reads
    rd(8'h08, d); chk("R4 enable reads 0", d, 32'h0);
    rd(8'h0C, d); chk("R4 disable reads 0", d, 32'h0);
    rd(8'h00, d); chk("R4 unmapped reads 0", d, 32'h0);

    // R2 / R3 mask set and clear
    wr(8'h08, 32'h14);
    rd(8'h10, d); chk("R2 enable sets", d, 32'h14);
    wr(8'h08, 32'h01);
    rd(8'h10, d); chk("R2 enable leaves others", d, 32'h15);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R2 only implemented bits", d, 32'h7D);
    wr(8'h0C, 32'h04);
    rd(8'h10, d); chk("R3 disable clears", d, 32'h79);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R3 disable all", d, 32'h0);

    // R12 watermark readback
    wr(8'h28, 32'd17);
    wr(8'h2C, 32'd45);
    rd(8'h28, d); chk("R12 tx watermark", d, 32'd17);
    rd(8'h2C, d); chk("R12 rx watermark", d, 32'd45);

    // R5 R6 R7 table of level patterns
    for (int i = 0; i < 8; i++) begin
      logic [30:0] v;
      v = VEC[i];
      wr(8'h28, {26'd0, v[18:13]});
      wr(8'h2C, {26'd0, v[12:7]});
      tx_level = v[30:25]; rx_level = v[24:19];
      @(negedge clk);
      wr(8'h04, 32'h7F);
      rd(8'h04, d);
      chk($sformatf("R5 R6 R7 vector %0d", i), d, {25'd0, v[6:0]});
    end

    // quiet levels: no level flags with these settings
    wr(8'h28, 32'd1); wr(8'h2C, 32'd32);
    tx_level = 6'd10; rx_level = 6'd0;
    @(negedge clk);
    wr(8'h04, 32'h7F);
    rd(8'h04, d); chk("R9 all cleared", d, 32'h0);

    // R8 sticky events
    rx_ovf_pulse = 1'b1; @(negedge clk); rx_ovf_pulse = 1'b0;
    tx_udf_pulse = 1'b1; @(negedge clk); tx_udf_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h04, d); chk("R8 events held", d, 32'h41);

    // R9 selective clear
    wr(8'h04, 32'h01);
    rd(8'h04, d); chk("R9 clear bit 0 only", d, 32'h40);

    // R9 event in the clearing cycle wins
    rx_ovf_pulse = 1'b1; reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h01;
    @(negedge clk);
    rx_ovf_pulse = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(8'h04, d); chk("R9 event beats clear", d, 32'h41);

    // R9 level condition held during clear stays set
    tx_level = 6'd0;
    @(negedge clk);
    wr(8'h04, 32'h04);
    rd(8'h04, d); chk("R9 level bit reasserts", d, 32'h45);
    tx_level = 6'd10;
    @(negedge clk);
    wr(8'h04, 32'h05);
    rd(8'h04, d); chk("R9 cleared leaving bit 6", d, 32'h40);

    // R10 interrupt
    @(negedge clk);
    chk("R10 masked no irq", {31'd0, irq}, 32'd0);
    wr(8'h08, 32'h40);
    @(negedge clk);
    chk("R10 irq raised", {31'd0, irq}, 32'd1);
    wr(8'h04, 32'h40);
    @(negedge clk);
    chk("R10 irq dropped after clear", {31'd0, irq}, 32'd0);
    wr(8'h08, 32'h08);
    tx_level = 6'd63;
    @(negedge clk);
    @(negedge clk);
    chk("R10 R6 irq from full", {31'd0, irq}, 32'd1);
    wr(8'h0C, 32'h08);
    @(negedge clk);
    chk("R10 R3 irq off after disable", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule